// File: doc/BRIEF.md
# Prescaled interval countdown timer

An 8-bit interval timer sitting on a small processor bus. Software starts a timed interval with a single bus write: the written byte becomes the count, and the low two address bits of that write choose how many clocks one count unit lasts. The count begins falling on the next clock, with no separate start command. Reading the timer returns the present count, so a polling loop can wait for zero.

Once the count has sat at zero for one full unit, the timer passes to 0xFF, stops using the prescaler and keeps falling once per clock through negative two's-complement values. Software that comes late to the expiry can read how many clocks ago the interval ended, or can compare against a series of negative targets (for example one unit of bit time apart) to sample at fixed points without drift. A sticky flag output records each passage from 0x00 to 0xFF until software reads the count or writes a new one.

Top module: `iv_timer`

## Requirements
- R1: After reset, rd_data and irq_flag are 0 and the count holds at 0 without running until the first write.
- R2: A write selects the clocks per count unit from addr[1:0]: 0 gives 1, 1 gives 8, 2 gives 64, 3 gives 1024.
- R3: A write (cs=1, we=1) loads wr_data as the count at that clock edge, and the count then drops by one at each multiple of the unit after the write edge; with 8 clocks per unit and 2 loaded, reads at edges 3, 9 and 21 after the write return 2, 1 and 0.
- R4: A read (cs=1, we=0) at edge k returns on rd_data, from edge k on, the count held just before edge k; a decrement at edge k is not visible to that read.
- R5: The count stays at 0 for one full unit and then becomes 0xFF; with N loaded and D clocks per unit this happens at edge (N+1)*D after the write.
- R6: From the edge the count first becomes 0xFF it falls by one at every clock, ignoring the prescaler, and wraps from 0x00 to 0xFF without reloading.
- R7: irq_flag becomes 1 at the edge where the count passes from 0x00 to 0xFF (the first one or any later wrap) and stays 1 until cleared.
- R8: A read clears irq_flag, except that a passage from 0x00 to 0xFF at the same edge leaves it set.
- R9: A write at any time clears irq_flag, reloads the count, reselects the prescaler and restarts the prescaler phase from zero, also after expiry.
- R10: With cs=0 the bus inputs are ignored: the count follows its schedule unchanged and rd_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Bus select for this cycle |
| we | input | 1 | 1 = write, 0 = read (with cs) |
| addr | input | 2 | Prescale select on writes |
| wr_data | input | 8 | Count to load |
| rd_data | output | 8 | Registered count returned by the last read |
| irq_flag | output | 1 | Sticky expiry flag |

## Verification
The assertions watch, on every cycle, that a load takes the written value, that a halted counter stays still, that an expired counter falls by exactly one per clock, that the zero-to-0xFF passage switches to free running and sets the flag, that reads capture the pre-edge count and that rd_data holds without a read. Only the bench scenarios can show the long-range schedule: the exact edge at which each prescaled decrement lands for all four unit sizes, the full unit spent at zero, a restart of the prescaler phase by a mid-unit rewrite, the flag set winning against a read at the same edge, and the wrap 256 clocks after expiry.

// File: rtl/iv_timer_pkg.sv
package iv_timer_pkg;
  typedef enum logic [1:0] {
    DIV_1    = 2'd0,
    DIV_8    = 2'd1,
    DIV_64   = 2'd2,
    DIV_1024 = 2'd3
  } div_sel_e;

  // log2 of clocks per unit, one 4-bit field per select value
  localparam logic [15:0] DEF_SHIFTS = {4'd10, 4'd6, 4'd3, 4'd0};
endpackage

// File: rtl/iv_prescaler.sv
module iv_prescaler #(
  parameter int ADDR_W = 2,
  parameter int PRE_W  = 10,
  parameter int SH_W   = 4,
  parameter logic [SH_W*(1<<ADDR_W)-1:0] SHIFT_TAB = iv_timer_pkg::DEF_SHIFTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [ADDR_W-1:0] sel,
  input  logic              run,
  input  logic              bypass,
  output logic              tick
);
  localparam int NUM_DIV = 1 << ADDR_W;

  logic [PRE_W-1:0]  lim [NUM_DIV];
  logic [PRE_W-1:0]  phase;
  logic [ADDR_W-1:0] sel_q;

  genvar g;
  generate
    for (g = 0; g < NUM_DIV; g++) begin : g_lim
      assign lim[g] = PRE_W'((32'd1 << SHIFT_TAB[g*SH_W +: SH_W]) - 32'd1);
    end
  endgenerate

  assign tick = run && !restart && (bypass || (phase == lim[sel_q]));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      sel_q <= '0;
    end else if (restart) begin
      phase <= '0;
      sel_q <= sel;
    end else if (!run || bypass || tick) begin
      phase <= '0;
    end else begin
      phase <= phase + PRE_W'(1);
    end
  end

  // R2
  phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= lim[sel_q]);
endmodule

// File: rtl/iv_count_core.sv
module iv_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expired,
  output logic             running,
  output logic             wrap
);
  assign wrap = tick && running && !load && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      expired <= 1'b0;
      running <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      expired <= 1'b0;
      running <= 1'b1;
    end else if (tick && running) begin
      count <= count - CNT_W'(1);
      if (count == '0) expired <= 1'b1;
    end
  end

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !load) |=> $stable(count));
  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val)) && !expired);
  // R5
  zero_exit_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> expired && (count == '1));
  // R6
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/iv_flag.sv
module iv_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr_rd,
  input  logic clr_wr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (clr_wr) flag <= 1'b0;
    else if (set)    flag <= 1'b1;
    else if (clr_rd) flag <= 1'b0;
  end

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set && !clr_wr) |=> flag);
  // R8
  flag_rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_rd && !set && !clr_wr) |=> !flag);
  // R9
  flag_wr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> !flag);
endmodule

// File: rtl/iv_timer.sv
module iv_timer #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2,
  parameter int PRE_W  = 10,
  parameter int SH_W   = 4,
  parameter logic [SH_W*(1<<ADDR_W)-1:0] SHIFT_TAB = iv_timer_pkg::DEF_SHIFTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq_flag
);
  logic             wr_en, rd_en, tick, expired, running, wrap;
  logic [CNT_W-1:0] count;

  assign wr_en = cs && we;
  assign rd_en = cs && !we;

  iv_prescaler #(
    .ADDR_W(ADDR_W), .PRE_W(PRE_W), .SH_W(SH_W), .SHIFT_TAB(SHIFT_TAB)
  ) u_pre (
    .clk(clk), .rst(rst), .restart(wr_en), .sel(addr),
    .run(running), .bypass(expired), .tick(tick)
  );

  iv_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .load(wr_en), .load_val(wr_data), .tick(tick),
    .count(count), .expired(expired), .running(running), .wrap(wrap)
  );

  iv_flag u_flag (
    .clk(clk), .rst(rst), .set(wrap), .clr_rd(rd_en), .clr_wr(wr_en),
    .flag(irq_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= count;
  end

  // R4
  read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data == $past(count)));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/iv_timer_bench.sv
module iv_timer_bench;
  import iv_timer_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq_flag;

  int vectors = 0, miscompares = 0;
  int pos = 0, cur_d = 1, cur_n = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  iv_timer u_iv_timer (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_flag(irq_flag)
  );

  function automatic int div_of(div_sel_e s);
    case (s)
      DIV_1:   return 1;
      DIV_8:   return 8;
      DIV_64:  return 64;
      default: return 1024;
    endcase
  endfunction

  // count held after m edges beyond the write edge
  function automatic logic [7:0] model(int m);
    int per, mu;
    per = m / cur_d;
    if (per <= cur_n) return 8'(cur_n - per);
    mu = (cur_n + 1) * cur_d;
    return 8'(255 - ((m - mu) % 256));
  endfunction

  task automatic idle(int n);
    cs = 1'b0; we = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(div_sel_e s, logic [7:0] v);
    cs = 1'b1; we = 1'b1; addr = s; wr_data = v;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    pos = 0; cur_d = div_of(s); cur_n = v;
  endtask

  task automatic read_raw(logic [7:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    cs = 1'b1; we = 1'b0;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic read_at(int k, string tag);
    if (k - pos - 1 > 0) idle(k - pos - 1);
    read_raw(model(k - 1), tag);
    pos = k;
  endtask

  task automatic idle_to(int k);
    idle(k - pos);
    pos = k;
  endtask

  task automatic check_flag(logic e, string tag);
    vectors++;
    if (irq_flag !== e) begin
      miscompares++;
      $display("FAIL %s irq_flag actual=%0b expected=%0b", tag, irq_flag, e);
    end
  endtask

  task automatic check_rd(logic [7:0] e, string tag);
    vectors++;
    if (rd_data !== e) begin
      miscompares++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", tag, rd_data, e);
    end
  endtask

  // monitor: pops one expected item per completed read
  initial begin
    forever begin
      @(posedge clk);
      if (cs && !we) begin
        @(negedge clk);
        vectors++;
        if (exp_q.size() == 0) begin
          miscompares++;
          $display("FAIL scoreboard empty rd_data actual=%02h expected=none", rd_data);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if (rd_data !== e) begin
            miscompares++;
            $display("FAIL %s rd_data actual=%02h expected=%02h", t, rd_data, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_rd(8'h00, "R1 reset rd_data");
    check_flag(1'b0, "R1 reset flag");
    idle(10);
    read_raw(8'h00, "R1 halted before first write");
    check_flag(1'b0, "R1 no expiry while halted");

    // divide by 8, load 2
    bus_write(DIV_8, 8'd2);
    read_at(3, "R3 read at 3");
    read_at(8, "R4 same-edge decrement hidden");
    read_at(9, "R3 read at 9");
    read_at(21, "R3 read at 21");
    read_at(24, "R5 zero for full unit");
    check_flag(1'b1, "R8 set wins over read");
    read_at(25, "R5 passes to FF");
    check_flag(1'b0, "R8 read clears flag");
    read_at(26, "R6 per-clock after expiry");
    idle_to(100);
    cs = 1'b0; we = 1'b1; wr_data = 8'h55; addr = 2'd3;
    @(negedge clk); we = 1'b0; pos = 101;
    read_at(103, "R10 deselected write ignored");
    check_rd(model(102), "R10 rd_data holds");
    idle_to(279);
    check_flag(1'b0, "R7 no flag before wrap");
    idle_to(280);
    check_flag(1'b1, "R7 wrap sets flag");
    read_at(281, "R6 wrap to FF");

    // divide by 1, load 5
    bus_write(DIV_1, 8'd5);
    check_flag(1'b0, "R9 write clears flag");
    read_at(3, "R2 divide by 1");
    idle_to(5);
    check_flag(1'b0, "R7 flag clear before expiry");
    idle_to(6);
    check_flag(1'b1, "R7 expiry sets flag");
    idle_to(40);
    check_flag(1'b1, "R7 flag sticky");

    // rewrite while expired, then mid-unit rewrite
    bus_write(DIV_8, 8'd3);
    check_flag(1'b0, "R9 write clears flag after expiry");
    read_at(9, "R9 prescaler back after expiry");
    idle_to(12);
    bus_write(DIV_8, 8'd3);
    read_at(8, "R9 phase restarted");
    read_at(9, "R9 phase restarted decrement");

    // divide by 64, load 1
    bus_write(DIV_64, 8'd1);
    read_at(64, "R2 divide by 64 before unit");
    read_at(65, "R2 divide by 64 after unit");
    read_at(129, "R5 divide by 64 expiry");

    // divide by 1024, load 1
    bus_write(DIV_1024, 8'd1);
    read_at(1024, "R2 divide by 1024 before unit");
    read_at(1025, "R2 divide by 1024 after unit");
    cs = 1'b0; we = 1'b1; wr_data = 8'hA0; addr = 2'd0;
    @(negedge clk); we = 1'b0; pos = 1026;
    check_rd(8'h00, "R10 rd_data holds while deselected");
    read_at(2049, "R5 divide by 1024 expiry");

    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule